// File: doc/BRIEF.md
# Video Encoder Reconfiguration Sequencer

This block is a host-side state machine that walks the control lines of an attached video encoder through a safe reconfiguration whenever a new output mode needs a different PLL frequency. A request carries a new mode code and a flag saying whether the PLL frequency changes. For a frequency change, the block first blanks the DAC outputs. It then stops the PLL, holds the encoder's internal filter in reset and presents the new mode code. Next it restarts the PLL and waits out a settling interval longer than 2 ms. Only then does it release the filter reset and turn the DAC back on.

Two configuration inputs let the block leave the DAC alone for the whole sequence. One is set when an external video-mute circuit handles blanking. The other is set when the filter-reset control is kept in its running state during normal operation. A request that needs no PLL frequency change skips the whole sequence: the new mode code is applied directly. The settling count is derived from a clock-frequency parameter, and a busy output plus a one-cycle done pulse report progress to the host.

Top module: `vid_reconfig_seq`

## Requirements
- R1: After reset the block is idle with busy=0, done=0, dac_en=1, pll_run=1, filt_rst_n=1 and mode_sel=0.
- R2: A request (req_valid=1, req_pll_chg=1) seen at a clock edge while busy=0 is accepted, and busy is 1 from the following cycle.
- R3: Without DAC skip, dac_en drops on acceptance and stays low for GAP_CYC cycles while pll_run and filt_rst_n remain 1.
- R4: The halt phase lasts GAP_CYC cycles with pll_run=0, filt_rst_n=0 and mode_sel equal to the requested code.
- R5: After the halt phase pll_run returns to 1 while filt_rst_n stays 0 for exactly SETTLE_CYC = floor(CLK_HZ*SETTLE_US/1e6)+1 cycles, which is strictly more than SETTLE_US.
- R6: Without DAC skip, filt_rst_n rises after the settling interval, then GAP_CYC cycles later dac_en rises in the same cycle that busy falls and done is 1.
- R7: If cfg_ext_mute or cfg_filt_hold is 1 at acceptance, dac_en stays 1 throughout, the halt phase starts on acceptance, and busy falls with done=1 in the cycle filt_rst_n rises.
- R8: A request with req_pll_chg=0 while busy=0 updates mode_sel in the next cycle with done=1, leaving busy, dac_en, pll_run and filt_rst_n unchanged.
- R9: Requests that arrive while busy=1 are ignored, and mode_sel holds its value from the start of the halt phase through the end of the sequence.
- R10: done is a single-cycle pulse and is never 1 together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode-change request strobe |
| req_mode | input | MODE_W | New mode code |
| req_pll_chg | input | 1 | 1 when the new mode needs a PLL frequency change |
| cfg_ext_mute | input | 1 | External mute present: leave DAC untouched |
| cfg_filt_hold | input | 1 | Filter-reset control kept running: leave DAC untouched |
| dac_en | output | 1 | DAC output enable |
| pll_run | output | 1 | PLL run control |
| filt_rst_n | output | 1 | Encoder filter reset, active low |
| mode_sel | output | MODE_W | Mode code presented to the encoder |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sequence is run with DAC handling active, with each of the two skip options set alone and with both set, and with random mode codes. These runs separate the full five-phase timeline from the shortened one, and each step's cycle count is checked against its phase boundaries. Direct mode changes without a PLL change are mixed in to check that they never start the timed sequence. Random requests injected during busy cycles show whether a late request disturbs the timeline or the presented mode code. Back-to-back requests issued on the very cycle done appears show that a new sequence is accepted right away.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DACOFF  = 3'd1,
    PH_HALT    = 3'd2,
    PH_RESTART = 3'd3,
    PH_RELEASE = 3'd4
  } phase_e;

  // Cycles strictly greater than the interval: floor(hz*us/1e6) + 1
  function automatic longint unsigned settle_cycles(input longint unsigned hz,
                                                    input longint unsigned us);
    return (hz * us) / 64'd1_000_000 + 64'd1;
  endfunction
endpackage

// File: rtl/vrs_req_decode.sv
module vrs_req_decode (
  input  logic req_valid,
  input  logic req_pll_chg,
  input  logic busy,
  input  logic cfg_ext_mute,
  input  logic cfg_filt_hold,
  output logic accept,
  output logic bypass,
  output logic skip_dac
);
  always_comb begin
    accept   = req_valid && req_pll_chg && !busy;
    bypass   = req_valid && !req_pll_chg && !busy;
    skip_dac = cfg_ext_mute || cfg_filt_hold;
  end
endmodule

// File: rtl/vrs_timer.sv
module vrs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R5: a loaded count always runs down by exactly one per cycle
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/vrs_ctrl.sv
module vrs_ctrl
  import vrs_pkg::*;
#(
  parameter int MODE_W     = 3,
  parameter int CNT_W      = 8,
  parameter int GAP_CYC    = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              bypass,
  input  logic              skip_dac,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              tmr_exp,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              dac_en,
  output logic              pll_run,
  output logic              filt_rst_n,
  output logic [MODE_W-1:0] mode_sel,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  phase_e            st_q;
  logic              skip_q;
  logic [MODE_W-1:0] pend_q;

  // Timer reload on every phase entry except the return to idle
  always_comb begin
    tmr_load = 1'b0;
    unique case (st_q)
      PH_IDLE:    tmr_load = accept;
      PH_DACOFF:  tmr_load = tmr_exp;
      PH_HALT:    tmr_load = tmr_exp;
      PH_RESTART: tmr_load = tmr_exp && !skip_q;
      PH_RELEASE: tmr_load = 1'b0;
      default:    tmr_load = 1'b0;
    endcase
    tmr_val = (st_q == PH_HALT) ? SETTLE_LD : GAP_LD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PH_IDLE;
      skip_q     <= 1'b0;
      pend_q     <= '0;
      dac_en     <= 1'b1;
      pll_run    <= 1'b1;
      filt_rst_n <= 1'b1;
      mode_sel   <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (accept) begin
            busy   <= 1'b1;
            skip_q <= skip_dac;
            pend_q <= req_mode;
            if (skip_dac) begin
              st_q       <= PH_HALT;
              pll_run    <= 1'b0;
              filt_rst_n <= 1'b0;
              mode_sel   <= req_mode;
            end else begin
              st_q   <= PH_DACOFF;
              dac_en <= 1'b0;
            end
          end else if (bypass) begin
            mode_sel <= req_mode;
            done     <= 1'b1;
          end
        end
        PH_DACOFF: if (tmr_exp) begin
          st_q       <= PH_HALT;
          pll_run    <= 1'b0;
          filt_rst_n <= 1'b0;
          mode_sel   <= pend_q;
        end
        PH_HALT: if (tmr_exp) begin
          st_q    <= PH_RESTART;
          pll_run <= 1'b1;
        end
        PH_RESTART: if (tmr_exp) begin
          filt_rst_n <= 1'b1;
          if (skip_q) begin
            st_q <= PH_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            st_q <= PH_RELEASE;
          end
        end
        PH_RELEASE: if (tmr_exp) begin
          st_q   <= PH_IDLE;
          dac_en <= 1'b1;
          busy   <= 1'b0;
          done   <= 1'b1;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  // Settling monitor: cycles with PLL running and filter still in reset
  logic [CNT_W:0] gap_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)                                       gap_cnt_q <= '0;
    else if (pll_run && !filt_rst_n && !(&gap_cnt_q)) gap_cnt_q <= gap_cnt_q + 1'b1;
    else if (!(pll_run && !filt_rst_n))            gap_cnt_q <= '0;
  end

  // R5
  settle_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_rst_n) |-> (gap_cnt_q >= (CNT_W+1)'(SETTLE_CYC)));
  // R6
  dac_on_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_en) |-> (filt_rst_n && pll_run && done));
  // R4
  pll_restart_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_run) |-> !filt_rst_n);
  // R3
  dac_off_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !dac_en |-> busy);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q inside {PH_HALT, PH_RESTART, PH_RELEASE}) &&
     ($past(st_q) inside {PH_HALT, PH_RESTART, PH_RELEASE})) |-> $stable(mode_sel));
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !$past(done)));
endmodule

// File: rtl/vid_reconfig_seq.sv
module vid_reconfig_seq
  import vrs_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter longint CLK_HZ = 100_000_000,
  parameter int SETTLE_US = 2000,
  parameter int GAP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_pll_chg,
  input  logic              cfg_ext_mute,
  input  logic              cfg_filt_hold,
  output logic              dac_en,
  output logic              pll_run,
  output logic              filt_rst_n,
  output logic [MODE_W-1:0] mode_sel,
  output logic              busy,
  output logic              done
);
  localparam int SETTLE_CYC = int'(settle_cycles(CLK_HZ, SETTLE_US));
  localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             accept, bypass, skip_dac;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;

  vrs_req_decode u_dec (
    .req_valid    (req_valid),
    .req_pll_chg  (req_pll_chg),
    .busy         (busy),
    .cfg_ext_mute (cfg_ext_mute),
    .cfg_filt_hold(cfg_filt_hold),
    .accept       (accept),
    .bypass       (bypass),
    .skip_dac     (skip_dac)
  );

  vrs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  vrs_ctrl #(
    .MODE_W    (MODE_W),
    .CNT_W     (CNT_W),
    .GAP_CYC   (GAP_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .bypass    (bypass),
    .skip_dac  (skip_dac),
    .req_mode  (req_mode),
    .tmr_exp   (tmr_exp),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .dac_en    (dac_en),
    .pll_run   (pll_run),
    .filt_rst_n(filt_rst_n),
    .mode_sel  (mode_sel),
    .busy      (busy),
    .done      (done)
  );

  initial begin
    // R5
    gap_param_chk: assert (GAP_CYC >= 1 && SETTLE_CYC >= 2);
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pll_chg && !busy) |=> busy);
  // R8
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_pll_chg && !busy) |=> (!busy && done && pll_run && filt_rst_n && dac_en));
endmodule

// File: tb/vid_reconfig_seq_bench.sv
module vid_reconfig_seq_bench;
  localparam int MODE_W = 3;
  localparam longint CLK_HZ = 10_000;
  localparam int SETTLE_US = 2000;
  localparam int G = 3;
  // Independent of the RTL: 10 kHz * 2 ms = 20 cycles, strictly more gives 21
  localparam int S = 21;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_pll_chg = 0, cfg_ext_mute = 0, cfg_filt_hold = 0;
  logic [MODE_W-1:0] req_mode = '0;
  logic dac_en, pll_run, filt_rst_n, busy, done;
  logic [MODE_W-1:0] mode_sel;

  int n_tests = 0, n_fail = 0;
  logic [MODE_W-1:0] cur_mode = '0;

  always #5 clk = ~clk;

  vid_reconfig_seq #(.MODE_W(MODE_W), .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US),
                     .GAP_CYC(G)) u_vid_reconfig_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_pll_chg(req_pll_chg), .cfg_ext_mute(cfg_ext_mute),
    .cfg_filt_hold(cfg_filt_hold), .dac_en(dac_en), .pll_run(pll_run),
    .filt_rst_n(filt_rst_n), .mode_sel(mode_sel), .busy(busy), .done(done));

  // Expected {dac_en, pll_run, filt_rst_n, busy, done} at sample t after acceptance
  function automatic logic [4:0] exp_ctl(int t, bit skip);
    if (skip) begin
      if (t <= G)          return 5'b10010;   // R7 halt from acceptance
      else if (t <= G + S) return 5'b11010;   // R5 settling
      else if (t == G+S+1) return 5'b11101;   // R7 release + done
      else                 return 5'b11100;
    end else begin
      if (t <= G)              return 5'b01110; // R3
      else if (t <= 2*G)       return 5'b00010; // R4
      else if (t <= 2*G+S)     return 5'b01010; // R5
      else if (t <= 3*G+S)     return 5'b01110; // R6 filter released
      else if (t == 3*G+S+1)   return 5'b11101; // R6 dac on + done
      else                     return 5'b11100;
    end
  endfunction

  function automatic int seq_len(bit skip);
    return skip ? (G + S + 1) : (3*G + S + 1);
  endfunction

  function automatic bit mode_is_new(int t, bit skip);
    return skip ? (t >= 1) : (t >= G + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic run_seq(logic [MODE_W-1:0] m, bit mute, bit hold, bit noise,
                         bit chain);
    bit skip = mute | hold;
    int len = seq_len(skip);
    req_valid = 1; req_pll_chg = 1; req_mode = m;
    cfg_ext_mute = mute; cfg_filt_hold = hold;
    for (int t = 1; t <= len; t++) begin
      @(negedge clk);
      req_valid = 0;
      chk(skip ? "R7/R2 ctl" : "R2-R6 ctl",
          {27'd0, dac_en, pll_run, filt_rst_n, busy, done}, {27'd0, exp_ctl(t, skip)});
      chk("R9 mode_sel", {29'd0, mode_sel},
          {29'd0, mode_is_new(t, skip) ? m : cur_mode});
      if (noise && t < len) begin
        // R9 requests while busy must be ignored
        req_valid = 1'($urandom_range(0, 1));
        req_pll_chg = 1'($urandom_range(0, 1));
        req_mode = MODE_W'($urandom);
        cfg_ext_mute = 1'($urandom_range(0, 1));
        cfg_filt_hold = 1'($urandom_range(0, 1));
      end
    end
    cur_mode = m;
    req_valid = 0; cfg_ext_mute = 0; cfg_filt_hold = 0;
    if (!chain) begin
      @(negedge clk);
      // R10 done lasts one cycle
      chk("R10 done", {30'd0, done, busy}, 32'd0);
    end
  endtask

  task automatic run_bypass(logic [MODE_W-1:0] m);
    req_valid = 1; req_pll_chg = 0; req_mode = m;
    @(negedge clk);
    req_valid = 0;
    chk("R8 bypass", {27'd0, dac_en, pll_run, filt_rst_n, busy, done}, 32'b11101);
    chk("R8 mode_sel", {29'd0, mode_sel}, {29'd0, m});
    cur_mode = m;
    @(negedge clk);
    chk("R10 bypass done", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 reset", {27'd0, dac_en, pll_run, filt_rst_n, busy, done}, 32'b11100);
    chk("R1 mode_sel", {29'd0, mode_sel}, 32'd0);
    // directed corners
    run_seq(3'd5, 0, 0, 0, 0);
    run_seq(3'd2, 1, 0, 0, 0);
    run_seq(3'd7, 0, 1, 0, 0);
    run_seq(3'd1, 1, 1, 1, 0);
    run_bypass(3'd6);
    run_seq(3'd4, 0, 0, 1, 0);
    // R2 back-to-back: new request on the done cycle is accepted at once
    @(negedge clk);
    run_seq(3'd3, 0, 0, 0, 1);
    run_seq(3'd0, 1, 0, 0, 0);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [MODE_W-1:0] m = MODE_W'($urandom);
      if ($urandom_range(0, 3) == 0) run_bypass(m);
      else run_seq(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule